// File: doc/BRIEF.md
# Clock Frequency Ratio Monitor

This block measures how fast an unknown monitored clock runs compared with a known reference clock. It publishes the result in the reference domain as an unsigned fixed-point word. The low FRAC_BITS bits of the word hold the fraction and the upper INT_BITS bits hold the integer part of f_mon / f_ref. The defaults are 16 and 16.

While the enable is high, the block repeats one measurement after another. For each one, the reference side opens a window of exactly 2^FRAC_BITS reference cycles, and a counter in the monitored domain counts its own clock edges during that window. Because the window length is a power of two, the final count is already the ratio in fixed point and no divider is needed. At the end of the window the monitored counter stops and holds its value. Only once the frozen state has been acknowledged back does the reference side capture the count. The next window then clears the counter and starts it again, so the design has no separate hold register.

If the monitored clock stops, no acknowledge ever arrives. The reference side then times out and reports a ratio of zero. Reducing INT_BITS shrinks the counter and the output word. A count that does not fit saturates at all ones.

Top module: `clk_ratio_monitor`

## Requirements
- R1: During and right after reset (ref_rst_n low), ratio reads 0 and ratio_upd is low.
- R2: With a steady monitored clock, each report gives ratio = round(f_mon / f_ref * 2^FRAC_BITS) within ±4 LSB. The count is taken from a monitored counter that holds constant while it is being transferred.
- R3: ratio_upd is high for exactly one reference cycle per report, and ratio changes only in a cycle where ratio_upd is high.
- R4: When the monitored clock stops, a report with ratio 0 follows within 3 * 2^FRAC_BITS + 50 reference cycles. Further zero reports follow for as long as the clock stays stopped.
- R5: While en is low, no new measurement starts. After any iteration already in progress has reported, ratio holds and ratio_upd stays low. Raising en again resumes the measurements.
- R6: When the true ratio needs more than INT_BITS integer bits, ratio reads all ones (2^(INT_BITS+FRAC_BITS) - 1) and does not wrap.
- R7: After a stopped monitored clock restarts, later reports return to the value given by R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Known reference clock; times the window and owns the result |
| ref_rst_n | input | 1 | Active-low synchronous reset in the reference domain; also resynchronised into the monitored domain |
| mon_clk | input | 1 | Unknown clock being measured; may stop at any time |
| en | input | 1 | Allows new measurement iterations to start (reference domain) |
| ratio | output | INT_BITS+FRAC_BITS | Last reported ratio, unsigned fixed point with FRAC_BITS fraction bits |
| ratio_upd | output | 1 | One-cycle strobe marking a new ratio value |

## Verification
The hardest case to reach from the ports is a monitored clock that dies partway through an iteration. Depending on where it stops, the acknowledge can be stuck high or stuck low, and only the timeout path in the reference controller produces the zero report. The bench gates its monitored clock generator at an arbitrary moment and then measures the latency to the first zero report against the worst-case bound. It then restarts the clock to show that the handshake recovers. A second instance built with a one-bit integer part shares the same monitored clock, so a fast clock drives its counter into saturation while the wide instance still reports the true value.

// File: rtl/cfm_pkg.sv
`timescale 1ns/1ps
// Shared types for the clock frequency ratio monitor.
package cfm_pkg;
    // Reference-side controller phases.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,  // waiting for enable and a lowered acknowledge
        ST_RUN   = 2'd1,  // window open, monitored counter running
        ST_DRAIN = 2'd2   // window closed, waiting for the freeze acknowledge
    } ref_state_t;
endpackage

// File: rtl/cfm_sync.sv
`timescale 1ns/1ps
// Multi-flop synchroniser for a single level signal.
// Assumes: d is a level that stays put for several destination clocks.
// Reset is synchronous and active low; tie rst_n high for a reset synchroniser.
module cfm_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/cfm_mon_counter.sv
`timescale 1ns/1ps
// Monitored-domain edge counter with freeze-and-hold transfer.
// Assumes: run_req is a level from the reference domain. Its rising edge
// (after synchronisation) clears and starts the count. Its falling edge
// freezes the count, and the count then holds until the next rising edge.
// run_echo returns the synchronised level so that the reference side knows
// the count is frozen before it reads cnt.
module cfm_mon_counter #(
    parameter int W = 32
) (
    input  logic         mon_clk,
    input  logic         mon_rst_n,
    input  logic         run_req,
    output logic [W-1:0] cnt,
    output logic         run_echo
);
    localparam logic [W-1:0] CNT_MAX = '1;

    logic run_s;
    logic run_q;

    cfm_sync #(.STAGES(2), .RST_VAL(1'b0)) u_run_sync (
        .clk   (mon_clk),
        .rst_n (mon_rst_n),
        .d     (run_req),
        .q     (run_s)
    );

    // Delay the synchronised run level to find its rising edge.
    always_ff @(posedge mon_clk) begin
        if (!mon_rst_n) run_q <= 1'b0;
        else            run_q <= run_s;
    end

    // Clear on start, count with saturation while running, hold when stopped.
    always_ff @(posedge mon_clk) begin
        if (!mon_rst_n)                   cnt <= '0;
        else if (run_s && !run_q)         cnt <= '0;
        else if (run_s && cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end

    assign run_echo = run_s;
endmodule

// File: rtl/cfm_ref_ctrl.sv
`timescale 1ns/1ps
// Reference-domain controller. It times a window of 2^FRAC_BITS cycles,
// runs the run/acknowledge level handshake with the monitored side,
// captures the frozen count, and reports zero when the monitored side
// does not respond within one window.
// Assumes: cnt_in is stable whenever the synchronised acknowledge is low
// after a run phase.
module cfm_ref_ctrl
    import cfm_pkg::*;
#(
    parameter int W         = 32,
    parameter int FRAC_BITS = 16
) (
    input  logic         ref_clk,
    input  logic         ref_rst_n,
    input  logic         en,
    input  logic         ack_async,
    input  logic [W-1:0] cnt_in,
    output logic         run_req,
    output logic [W-1:0] ratio,
    output logic         ratio_upd
);
    localparam logic [FRAC_BITS-1:0] TMAX = '1;

    ref_state_t           state_q, state_d;
    logic [FRAC_BITS-1:0] timer_q, timer_d;
    logic                 seen_q, seen_d;
    logic                 req_d;
    logic                 ack_s;
    logic                 rep_cap, rep_zero;

    cfm_sync #(.STAGES(2), .RST_VAL(1'b0)) u_ack_sync (
        .clk   (ref_clk),
        .rst_n (ref_rst_n),
        .d     (ack_async),
        .q     (ack_s)
    );

    // Next-state logic: window timing, timeouts and report decisions.
    always_comb begin
        state_d  = state_q;
        timer_d  = timer_q;
        seen_d   = seen_q;
        req_d    = run_req;
        rep_cap  = 1'b0;
        rep_zero = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (en) begin
                    if (!ack_s) begin
                        req_d   = 1'b1;
                        timer_d = '0;
                        seen_d  = 1'b0;
                        state_d = ST_RUN;
                    end else if (timer_q == TMAX) begin
                        rep_zero = 1'b1;
                        timer_d  = '0;
                    end else begin
                        timer_d = timer_q + 1'b1;
                    end
                end
            end
            ST_RUN: begin
                timer_d = timer_q + 1'b1;
                if (ack_s) seen_d = 1'b1;
                if (timer_q == TMAX) begin
                    req_d = 1'b0;
                    if (seen_q || ack_s) begin
                        state_d = ST_DRAIN;
                    end else begin
                        rep_zero = 1'b1;
                        state_d  = ST_IDLE;
                    end
                end
            end
            ST_DRAIN: begin
                if (!ack_s) begin
                    rep_cap = 1'b1;
                    timer_d = '0;
                    state_d = ST_IDLE;
                end else if (timer_q == TMAX) begin
                    rep_zero = 1'b1;
                    timer_d  = '0;
                    state_d  = ST_IDLE;
                end else begin
                    timer_d = timer_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Register the controller state and the run request level.
    always_ff @(posedge ref_clk) begin
        if (!ref_rst_n) begin
            state_q <= ST_IDLE;
            timer_q <= '0;
            seen_q  <= 1'b0;
            run_req <= 1'b0;
        end else begin
            state_q <= state_d;
            timer_q <= timer_d;
            seen_q  <= seen_d;
            run_req <= req_d;
        end
    end

    // Publish the captured count or zero, with a one-cycle strobe.
    always_ff @(posedge ref_clk) begin
        if (!ref_rst_n) begin
            ratio     <= '0;
            ratio_upd <= 1'b0;
        end else begin
            ratio_upd <= rep_cap | rep_zero;
            if (rep_cap)       ratio <= cnt_in;
            else if (rep_zero) ratio <= '0;
        end
    end
endmodule

// File: rtl/clk_ratio_monitor.sv
`timescale 1ns/1ps
// Top level of the clock frequency ratio monitor.
// Reports f_mon / f_ref as unsigned INT_BITS.FRAC_BITS fixed point.
// Assumes: 1 <= INT_BITS <= 16, and ref_rst_n is held for several cycles of
// both clocks so that the monitored-domain reset synchroniser settles.
module clk_ratio_monitor #(
    parameter int INT_BITS  = 16,
    parameter int FRAC_BITS = 16,
    localparam int W        = INT_BITS + FRAC_BITS
) (
    input  logic         ref_clk,
    input  logic         ref_rst_n,
    input  logic         mon_clk,
    input  logic         en,
    output logic [W-1:0] ratio,
    output logic         ratio_upd
);
    logic         mon_rst_n;
    logic         run_req;
    logic         mon_run;
    logic [W-1:0] mon_cnt;

    // Carry the reference reset into the monitored domain.
    cfm_sync #(.STAGES(2), .RST_VAL(1'b0)) u_mrst (
        .clk   (mon_clk),
        .rst_n (1'b1),
        .d     (ref_rst_n),
        .q     (mon_rst_n)
    );

    cfm_mon_counter #(.W(W)) u_mon (
        .mon_clk   (mon_clk),
        .mon_rst_n (mon_rst_n),
        .run_req   (run_req),
        .cnt       (mon_cnt),
        .run_echo  (mon_run)
    );

    cfm_ref_ctrl #(.W(W), .FRAC_BITS(FRAC_BITS)) u_ctrl (
        .ref_clk   (ref_clk),
        .ref_rst_n (ref_rst_n),
        .en        (en),
        .ack_async (mon_run),
        .cnt_in    (mon_cnt),
        .run_req   (run_req),
        .ratio     (ratio),
        .ratio_upd (ratio_upd)
    );
endmodule

// File: rtl/cfm_checker.sv
`timescale 1ns/1ps
// Property checker for clk_ratio_monitor, bound to every instance.
module cfm_checker #(
    parameter int W = 32
) (
    input logic         ref_clk,
    input logic         ref_rst_n,
    input logic         mon_clk,
    input logic         mon_rst_n,
    input logic         en,
    input logic         run_req,
    input logic         mon_run,
    input logic [W-1:0] mon_cnt,
    input logic [W-1:0] ratio,
    input logic         ratio_upd
);
    localparam logic [W-1:0] CNT_MAX = '1;

    // R1: reset clears the published result.
    a_r1_reset_clear: assert property (@(posedge ref_clk)
        !ref_rst_n |=> (ratio == '0 && !ratio_upd));

    // R3: the strobe never lasts two cycles.
    a_r3_single_strobe: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        ratio_upd |=> !ratio_upd);

    // R3: the result moves only together with its strobe.
    a_r3_hold_between: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        !ratio_upd |-> $stable(ratio));

    // R5: with enable low and no run in progress, no run starts.
    a_r5_no_start: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        (!en && !run_req) |=> !run_req);

    // R2: the monitored count stays frozen while the stop is held.
    a_r2_frozen_hold: assert property (@(posedge mon_clk) disable iff (!mon_rst_n)
        (!mon_run && !$past(mon_run)) |-> $stable(mon_cnt));

    // R6: a saturated count stays at its maximum until it is restarted.
    a_r6_saturate: assert property (@(posedge mon_clk) disable iff (!mon_rst_n)
        (mon_cnt == CNT_MAX) |=> (mon_cnt == CNT_MAX || mon_cnt == '0));
endmodule

bind clk_ratio_monitor cfm_checker #(.W(W)) u_chk (
    .ref_clk   (ref_clk),
    .ref_rst_n (ref_rst_n),
    .mon_clk   (mon_clk),
    .mon_rst_n (mon_rst_n),
    .en        (en),
    .run_req   (run_req),
    .mon_run   (mon_run),
    .mon_cnt   (mon_cnt),
    .ratio     (ratio),
    .ratio_upd (ratio_upd)
);

// File: tb/sim_clk_ratio_monitor.sv
`timescale 1ns/1ps
module sim_clk_ratio_monitor;
    localparam real REF_PERIOD = 10.0;
    localparam int  FRAC       = 8;
    localparam int  WIN        = 1 << FRAC;
    localparam int  W0         = 16 + FRAC;
    localparam int  W1         = 1 + FRAC;

    typedef struct {
        int    exp;
        int    tol;
        string tag;
    } item_t;

    logic          ref_clk   = 1'b0;
    logic          ref_rst_n = 1'b0;
    logic          mon_clk   = 1'b0;
    logic          en        = 1'b0;
    logic [W0-1:0] ratio0;
    logic          upd0;
    logic [W1-1:0] ratio1;
    logic          upd1;

    real   mon_half = 2.0;
    bit    mon_on   = 1'b1;
    int    n_chk    = 0;
    int    n_bad    = 0;
    int    upd_cnt  = 0;
    int    dbl_upd  = 0;
    int    silent_chg = 0;
    item_t sb_q[$];

    clk_ratio_monitor #(.INT_BITS(16), .FRAC_BITS(FRAC)) u0 (
        .ref_clk(ref_clk), .ref_rst_n(ref_rst_n), .mon_clk(mon_clk),
        .en(en), .ratio(ratio0), .ratio_upd(upd0)
    );

    clk_ratio_monitor #(.INT_BITS(1), .FRAC_BITS(FRAC)) u1 (
        .ref_clk(ref_clk), .ref_rst_n(ref_rst_n), .mon_clk(mon_clk),
        .en(en), .ratio(ratio1), .ratio_upd(upd1)
    );

    always #(REF_PERIOD / 2.0) ref_clk = ~ref_clk;

    always begin
        if (mon_on) #(mon_half) mon_clk = ~mon_clk;
        else        #(1.0);
    end

    function automatic int exp_ratio(input real mon_period);
        return int'(REF_PERIOD / mon_period * real'(WIN));
    endfunction

    task automatic check_near(input int act, input int exp, input int tol, input string tag);
        n_chk++;
        if (act > exp + tol || act < exp - tol) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d (+/-%0d)", tag, act, exp, tol);
        end
    endtask

    // Driver: wait for n_skip reports to pass, queue an expectation, then
    // wait until the monitor has consumed it.
    task automatic expect_after(input int n_skip, input int exp, input int tol, input string tag);
        int    target;
        item_t it;
        target = upd_cnt + n_skip;
        wait (upd_cnt >= target);
        it.exp = exp;
        it.tol = tol;
        it.tag = tag;
        sb_q.push_back(it);
        wait (upd_cnt >= target + 1);
    endtask

    task automatic set_mon(input real period);
        mon_half = period / 2.0;
    endtask

    // Monitor: compare each report against the queued expectation and
    // record strobe-shape violations (R3).
    initial begin
        logic          prev_upd;
        logic [W0-1:0] prev_ratio;
        item_t         it;
        prev_upd   = 1'b0;
        prev_ratio = '0;
        forever begin
            @(negedge ref_clk);
            if (ref_rst_n) begin
                if (!upd0 && ratio0 != prev_ratio) silent_chg++;
                if (upd0) begin
                    if (prev_upd) dbl_upd++;
                    upd_cnt++;
                    if (sb_q.size() > 0) begin
                        it = sb_q.pop_front();
                        check_near(int'(ratio0), it.exp, it.tol, it.tag);
                    end
                end
            end
            prev_upd   = upd0;
            prev_ratio = ratio0;
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge ref_clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int t0;
        int lat;
        int upd_snap;
        int ratio_snap;

        set_mon(4.0);
        repeat (20) @(negedge ref_clk);
        // R1: reset state of both instances.
        check_near(int'(ratio0), 0, 0, "R1 ratio0 in reset");
        check_near(int'(upd0),   0, 0, "R1 upd0 in reset");
        check_near(int'(ratio1), 0, 0, "R1 ratio1 in reset");
        ref_rst_n = 1'b1;
        @(negedge ref_clk);
        check_near(int'(ratio0), 0, 0, "R1 ratio0 after reset");
        en = 1'b1;

        // R2: fast monitored clock; R6: narrow instance saturates.
        expect_after(2, exp_ratio(4.0), 4, "R2 period 4ns");
        @(negedge ref_clk);
        check_near(int'(ratio1), (1 << W1) - 1, 0, "R6 saturated narrow ratio");

        // R2: slow monitored clock, fits in the narrow instance as well.
        set_mon(25.0);
        expect_after(2, exp_ratio(25.0), 4, "R2 period 25ns");
        @(negedge ref_clk);
        check_near(int'(ratio1), exp_ratio(25.0), 4, "R6 narrow ratio in range");

        // R2: non-integer ratio.
        set_mon(7.0);
        expect_after(2, exp_ratio(7.0), 4, "R2 period 7ns");

        // R4: stop the monitored clock partway through an iteration.
        repeat (37) @(negedge ref_clk);
        mon_on = 1'b0;
        t0  = 0;
        lat = 0;
        while (lat == 0 && t0 < 4 * WIN + 100) begin
            @(negedge ref_clk);
            t0++;
            if (upd0 && ratio0 == '0) lat = t0;
        end
        n_chk++;
        if (lat == 0 || lat > 3 * WIN + 50) begin
            n_bad++;
            $display("FAIL R4 zero latency: got %0d expected 1..%0d", lat, 3 * WIN + 50);
        end
        expect_after(0, 0, 0, "R4 stays zero while stopped");

        // R7: restart the clock and recover.
        mon_on = 1'b1;
        expect_after(2, exp_ratio(7.0), 4, "R7 recovery after restart");

        // R5: enable low freezes the output.
        @(negedge ref_clk);
        en = 1'b0;
        repeat (2 * WIN + 50) @(negedge ref_clk);
        upd_snap   = upd_cnt;
        ratio_snap = int'(ratio0);
        repeat (3 * WIN) @(negedge ref_clk);
        check_near(upd_cnt, upd_snap, 0, "R5 no report while disabled");
        check_near(int'(ratio0), ratio_snap, 0, "R5 ratio held while disabled");
        en = 1'b1;
        expect_after(2, exp_ratio(7.0), 4, "R5 resume after enable");

        // R3: strobe shape over the whole run.
        check_near(dbl_upd, 0, 0, "R3 back-to-back strobes");
        check_near(silent_chg, 0, 0, "R3 ratio change without strobe");

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule